// File: doc/BRIEF.md
# Repeated-Tap FIR Multiply-Accumulate Sequencer

This block produces one output sample of an N-tap FIR filter. A start pulse hands it a tap count, a coefficient base address, a sample base address, a circular-mode flag and an address offset. It then walks both buffers through one shared data-memory read port. Each tap multiplies a signed 16-bit coefficient by a signed 16-bit sample and adds the product into a 32-bit accumulator. When the run ends it raises a one-cycle done pulse and presents the 32-bit sum.

The coefficient pointer always moves forward by one word. The sample pointer moves by one, or by the programmed offset when circular mode is selected, which lets a caller walk a ring buffer in either direction. The first coefficient is fetched before the loop begins. A repeat counter, loaded with N−2 at that point, decides how many further coefficients are fetched.

Interrupt requests that arrive during a run are held back. They are presented together once the run is over.

Top module: `fir_mac_seq`

## Requirements
- R1: With N ≥ 2 taps, the result equals the sum over k = 0..N−1 of coef_mem[coef_base+k] × smp_mem[a_k], where a_k = smp_base + k·step and the sum is taken modulo 2^AW. Both operands are signed two's complement.
- R2: When circ_i is 0, step is 1, so the sample addresses are smp_base, smp_base+1, and so on.
- R3: When circ_i is 1, step equals offset_i taken modulo 2^AW. This includes offset 0, and offsets that wrap the address downward, such as 16'hFFFF.
- R4: Count edges from the one that samples an accepted start, which is edge 0. In cycle 1 the block reads coef_base. For tap k it reads the sample address a_k in cycle 2+2k, then reads coef_base+k+1 in cycle 3+2k, but only if k < N−1. mem_rd_o is 0 in every other cycle, and there is at most one read per cycle. The read data is expected in the cycle after the address.
- R5: done_o is high for exactly one cycle, cycle 2N+3, so a run spans 2·(N+2) cycles including the start cycle. result_o is valid in that cycle and holds its value until the next accepted start.
- R6: Accumulation wraps modulo 2^32 with no saturation. For example, four products of (−32768)·(−32768) sum to 0.
- R7: A start_i pulse that arrives while a run is in progress is ignored. The run's addresses, timing and result are unchanged.
- R8: A tap count below 2 is rejected. done_o rises in cycle 1 with result_o equal to 0, and no memory read is issued.
- R9: While a run is in progress, irq_o is all zeros. Request bits seen on irq_i during the run are collected and presented on irq_o, OR-ed with the live irq_i, in the first idle cycle after done_o. When idle with nothing pending, irq_o follows irq_i.
- R10: After reset, done_o is 0, mem_rd_o is 0, result_o is 0 and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; only honoured while idle |
| taps_i | input | TW | Tap count N |
| coef_base_i | input | AW | Address of the first coefficient |
| smp_base_i | input | AW | Address of the first sample |
| circ_i | input | 1 | 1: the sample pointer steps by offset_i; 0: it steps by 1 |
| offset_i | input | AW | Sample pointer step used in circular mode |
| mem_rd_o | output | 1 | Read strobe to data memory |
| mem_addr_o | output | AW | Read address |
| mem_rdata_i | input | DW | Read data, valid one cycle after the address |
| result_o | output | 2*DW | Accumulated result |
| done_o | output | 1 | One-cycle completion pulse |
| irq_i | input | IRQW | Incoming interrupt requests |
| irq_o | output | IRQW | Interrupt requests, gated and held during a run |

## Verification
Every result has a fixed due cycle, counted from the edge that accepts start_i:
- the coefficient read is due in cycle 1;
- the read for tap k is due in cycle 2+2k, and the following coefficient read in cycle 3+2k;
- done_o and the sum are due in cycle 2N+3, or in cycle 1 for a rejected count;
- the held interrupts are due in cycle 2N+4.

The bench model builds, for each cycle of a run, the expected read strobe, address, done, result and interrupt values, and samples the outputs at the falling edge of that same cycle. It drives a second start and an interrupt in the middle of runs, then checks that the addresses and results still match the schedule of the original run.

// File: rtl/fir_mac_pkg.sv
`timescale 1ns/1ps
package fir_mac_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HEAD,
    ST_SMP,
    ST_COEF,
    ST_TAIL,
    ST_DONE
  } fir_state_e;

  localparam int unsigned MIN_TAPS = 2;

endpackage

// File: rtl/fir_seq_ctrl.sv
`timescale 1ns/1ps
module fir_seq_ctrl
  import fir_mac_pkg::*;
#(
  parameter int unsigned TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [TW-1:0] taps_i,
  output logic          accept_o,
  output logic          busy_o,
  output logic          head_o,
  output logic          smp_o,
  output logic          coef_o,
  output logic          coef_rd_o,
  output logic          done_o
);

  fir_state_e    state_q, state_d;
  logic [TW-1:0] taps_q;
  logic [TW-1:0] rpt_q;
  logic          last_q;
  logic          short_run;

  assign accept_o  = start_i && (state_q == ST_IDLE);
  assign short_run = taps_i < TW'(MIN_TAPS);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept_o) state_d = short_run ? ST_DONE : ST_HEAD;
      ST_HEAD: state_d = ST_SMP;
      ST_SMP:  state_d = ST_COEF;
      ST_COEF: state_d = last_q ? ST_TAIL : ST_SMP;
      ST_TAIL: state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      taps_q  <= '0;
      rpt_q   <= '0;
      last_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_o) taps_q <= taps_i;
      // repeat counter armed once the first coefficient is on its way
      if (state_q == ST_HEAD) begin
        rpt_q  <= taps_q - TW'(MIN_TAPS);
        last_q <= 1'b0;
      end else if (state_q == ST_COEF && !last_q) begin
        if (rpt_q == '0) last_q <= 1'b1;
        else             rpt_q  <= rpt_q - 1'b1;
      end
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign head_o    = (state_q == ST_HEAD);
  assign smp_o     = (state_q == ST_SMP);
  assign coef_o    = (state_q == ST_COEF);
  assign coef_rd_o = coef_o && !last_q;
  assign done_o    = (state_q == ST_DONE);

endmodule

// File: rtl/fir_addr_gen.sv
`timescale 1ns/1ps
module fir_addr_gen #(
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [AW-1:0] coef_base_i,
  input  logic [AW-1:0] smp_base_i,
  input  logic          circ_i,
  input  logic [AW-1:0] offset_i,
  input  logic          adv_coef_i,
  input  logic          adv_smp_i,
  output logic [AW-1:0] addr_o
);

  logic [AW-1:0] cptr_q, sptr_q, step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cptr_q <= '0;
      sptr_q <= '0;
      step_q <= AW'(1);
    end else if (ld_i) begin
      cptr_q <= coef_base_i;
      sptr_q <= smp_base_i;
      step_q <= circ_i ? offset_i : AW'(1);
    end else begin
      if (adv_coef_i) cptr_q <= cptr_q + AW'(1);
      if (adv_smp_i)  sptr_q <= sptr_q + step_q;
    end
  end

  assign addr_o = adv_smp_i ? sptr_q : cptr_q;

endmodule

// File: rtl/fir_mac_dp.sv
`timescale 1ns/1ps
module fir_mac_dp #(
  parameter int unsigned DW   = 16,
  parameter int unsigned ACCW = 2 * DW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            ld_coef_i,
  input  logic            ld_prod_i,
  input  logic [DW-1:0]   rdata_i,
  output logic [ACCW-1:0] acc_o
);

  logic [DW-1:0]          mreg_q;
  logic signed [ACCW-1:0] a_ext, b_ext, prod_d;
  logic [ACCW-1:0]        prod_q;
  logic                   prod_v_q;
  logic [ACCW-1:0]        acc_q;

  assign a_ext  = ACCW'($signed(mreg_q));
  assign b_ext  = ACCW'($signed(rdata_i));
  assign prod_d = a_ext * b_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mreg_q   <= '0;
      prod_q   <= '0;
      prod_v_q <= 1'b0;
      acc_q    <= '0;
    end else begin
      if (ld_coef_i) mreg_q <= rdata_i;
      prod_v_q <= ld_prod_i;
      if (ld_prod_i) prod_q <= prod_d;
      if (clr_i)         acc_q <= '0;
      else if (prod_v_q) acc_q <= acc_q + prod_q;
    end
  end

  assign acc_o = acc_q;

endmodule

// File: rtl/fir_irq_hold.sv
`timescale 1ns/1ps
module fir_irq_hold #(
  parameter int unsigned IRQW = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hold_i,
  input  logic [IRQW-1:0] irq_i,
  output logic [IRQW-1:0] irq_o
);

  for (genvar g = 0; g < IRQW; g++) begin : g_bit
    logic pend_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     pend_q <= 1'b0;
      else if (hold_i) pend_q <= pend_q | irq_i[g];
      else             pend_q <= 1'b0;
    end
    assign irq_o[g] = !hold_i && (irq_i[g] || pend_q);
  end

endmodule

// File: rtl/fir_mac_seq.sv
`timescale 1ns/1ps
module fir_mac_seq #(
  parameter int unsigned AW   = 16,
  parameter int unsigned DW   = 16,
  parameter int unsigned TW   = 8,
  parameter int unsigned IRQW = 4,
  localparam int unsigned ACCW = 2 * DW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [TW-1:0]   taps_i,
  input  logic [AW-1:0]   coef_base_i,
  input  logic [AW-1:0]   smp_base_i,
  input  logic            circ_i,
  input  logic [AW-1:0]   offset_i,
  output logic            mem_rd_o,
  output logic [AW-1:0]   mem_addr_o,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic [ACCW-1:0] result_o,
  output logic            done_o,
  input  logic [IRQW-1:0] irq_i,
  output logic [IRQW-1:0] irq_o
);

  logic accept, busy, head, smp, coef, coef_rd;

  fir_seq_ctrl #(.TW(TW)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .taps_i    (taps_i),
    .accept_o  (accept),
    .busy_o    (busy),
    .head_o    (head),
    .smp_o     (smp),
    .coef_o    (coef),
    .coef_rd_o (coef_rd),
    .done_o    (done_o)
  );

  fir_addr_gen #(.AW(AW)) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ld_i        (accept),
    .coef_base_i (coef_base_i),
    .smp_base_i  (smp_base_i),
    .circ_i      (circ_i),
    .offset_i    (offset_i),
    .adv_coef_i  (head || coef_rd),
    .adv_smp_i   (smp),
    .addr_o      (mem_addr_o)
  );

  fir_mac_dp #(.DW(DW), .ACCW(ACCW)) u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (accept),
    .ld_coef_i (smp),
    .ld_prod_i (coef),
    .rdata_i   (mem_rdata_i),
    .acc_o     (result_o)
  );

  fir_irq_hold #(.IRQW(IRQW)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (busy),
    .irq_i  (irq_i),
    .irq_o  (irq_o)
  );

  assign mem_rd_o = head || smp || coef_rd;

endmodule

// File: rtl/fir_mac_seq_chk.sv
`timescale 1ns/1ps
module fir_mac_seq_chk #(
  parameter int unsigned TW   = 8,
  parameter int unsigned ACCW = 32,
  parameter int unsigned IRQW = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic [TW-1:0]   taps_i,
  input logic            busy,
  input logic            mem_rd_o,
  input logic            done_o,
  input logic [ACCW-1:0] result_o,
  input logic [IRQW-1:0] irq_o
);

  assert_rd_in_run_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> busy);

  assert_done_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_result_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !start_i) |=> $stable(result_o));

  assert_run_not_restarted_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !done_o) |=> busy);

  assert_short_reject_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy && taps_i < TW'(2)) |=> (done_o && result_o == '0 && !mem_rd_o));

  assert_irq_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (irq_o == '0));

endmodule

bind fir_mac_seq fir_mac_seq_chk #(.TW(TW), .ACCW(ACCW), .IRQW(IRQW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .taps_i   (taps_i),
  .busy     (busy),
  .mem_rd_o (mem_rd_o),
  .done_o   (done_o),
  .result_o (result_o),
  .irq_o    (irq_o)
);

// File: tb/fir_mac_seq_tb_top.sv
`timescale 1ns/1ps
module fir_mac_seq_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  taps_i = '0;
  logic [15:0] coef_base_i = '0;
  logic [15:0] smp_base_i = '0;
  logic        circ_i = 1'b0;
  logic [15:0] offset_i = '0;
  logic        mem_rd_o;
  logic [15:0] mem_addr_o;
  logic [15:0] mem_rdata_i = '0;
  logic [31:0] result_o;
  logic        done_o;
  logic [3:0]  irq_i = '0;
  logic [3:0]  irq_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [15:0] mem [256];

  always #2 clk_i = ~clk_i;

  fir_mac_seq dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .taps_i      (taps_i),
    .coef_base_i (coef_base_i),
    .smp_base_i  (smp_base_i),
    .circ_i      (circ_i),
    .offset_i    (offset_i),
    .mem_rd_o    (mem_rd_o),
    .mem_addr_o  (mem_addr_o),
    .mem_rdata_i (mem_rdata_i),
    .result_o    (result_o),
    .done_o      (done_o),
    .irq_i       (irq_i),
    .irq_o       (irq_o)
  );

  // memory model with one-cycle read latency
  always @(posedge clk_i) if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o[7:0]];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model_sum(int n, int cb, int sb, int step);
    logic [31:0] acc = '0;
    for (int k = 0; k < n; k++) begin
      logic [15:0] ca = 16'(cb + k);
      logic [15:0] sa = 16'(sb + k * step);
      shortint c = shortint'(mem[ca[7:0]]);
      shortint s = shortint'(mem[sa[7:0]]);
      int p = int'(c) * int'(s);
      acc = acc + 32'(p);
    end
    return acc;
  endfunction

  // one run: every cycle from the start cycle to the first idle cycle is compared
  task automatic run_op(input int n, input int cb, input int sb, input bit circ,
                        input int off, input int irq_cyc, input logic [3:0] irq_val,
                        input bit poke, input string req);
    int          step  = circ ? (off & 16'hFFFF) : 1;
    int          total = (n < 2) ? 1 : 2 * n + 3;
    logic [31:0] exp_sum = (n < 2) ? 32'd0 : model_sum(n, cb, sb, step);
    logic [3:0]  held = (irq_cyc >= 1 && irq_cyc <= total) ? irq_val : 4'b0;
    start_i     = 1'b1;
    taps_i      = 8'(n);
    coef_base_i = 16'(cb);
    smp_base_i  = 16'(sb);
    circ_i      = circ;
    offset_i    = 16'(off);
    irq_i       = (irq_cyc == 0) ? irq_val : 4'b0;
    #1;
    chk(irq_o == irq_i, "R9", "idle pass-through", irq_o, irq_i);
    @(negedge clk_i);
    for (int cyc = 1; cyc <= total + 1; cyc++) begin
      bit          e_rd = 1'b0;
      logic [15:0] e_addr = '0;
      start_i = (poke && cyc == 4);
      if (poke && cyc == 4) begin
        taps_i = 8'd3; coef_base_i = 16'd0; smp_base_i = 16'd0; circ_i = 1'b0;
      end
      irq_i = (cyc == irq_cyc) ? irq_val : 4'b0;
      #1;
      if (n >= 2 && cyc <= 2 * n + 1) begin
        if (cyc == 1) begin
          e_rd = 1'b1; e_addr = 16'(cb);
        end else begin
          int j = cyc - 2;
          int k = j / 2;
          if (j % 2 == 0) begin e_rd = 1'b1; e_addr = 16'(sb + k * step); end
          else begin e_rd = (k < n - 1); e_addr = 16'(cb + k + 1); end
        end
      end
      chk(mem_rd_o == e_rd, req, $sformatf("R4 rd strobe cyc %0d", cyc), mem_rd_o, e_rd);
      if (e_rd)
        chk(mem_addr_o == e_addr, req, $sformatf("R4 address cyc %0d", cyc), mem_addr_o, e_addr);
      chk(done_o == (cyc == total), req, $sformatf("R5 done cyc %0d", cyc), done_o, cyc == total);
      if (cyc >= total)
        chk(result_o == exp_sum, req, $sformatf("R1 result cyc %0d", cyc), result_o, exp_sum);
      if (cyc <= total)
        chk(irq_o == 4'b0, "R9", $sformatf("gated cyc %0d", cyc), irq_o, 0);
      else
        chk(irq_o == (held | irq_i), "R9", "release", irq_o, held | irq_i);
      @(negedge clk_i);
    end
    start_i = 1'b0;
    irq_i   = 4'b0;
    @(negedge clk_i);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'((i * 40503 + 12345) ^ (i << 9));
    for (int i = 200; i < 208; i++) mem[i] = 16'h8000;
    repeat (3) @(negedge clk_i);
    chk(done_o == 1'b0 && mem_rd_o == 1'b0, "R10", "reset ctrl", {done_o, mem_rd_o}, 0);
    chk(result_o == 32'd0, "R10", "reset result", result_o, 0);
    chk(irq_o == 4'b0, "R10", "reset irq", irq_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    run_op(4, 10, 50, 1'b0, 0, 0, 4'b1000, 1'b0, "R2");
    run_op(8, 20, 100, 1'b1, 3, 5, 4'b0101, 1'b0, "R3");
    run_op(5, 30, 2, 1'b1, 16'hFFFF, 12, 4'b0010, 1'b0, "R3");
    run_op(4, 200, 200, 1'b1, 0, 0, 4'b0000, 1'b0, "R6");
    run_op(2, 60, 70, 1'b0, 0, 3, 4'b1111, 1'b0, "R5");
    run_op(1, 60, 70, 1'b0, 0, 1, 4'b0100, 1'b0, "R8");
    run_op(0, 60, 70, 1'b0, 0, 0, 4'b0001, 1'b0, "R8");
    run_op(6, 80, 150, 1'b1, 2, 9, 4'b1001, 1'b1, "R7");
    run_op(40, 5, 90, 1'b0, 0, 40, 4'b0110, 1'b0, "R1");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule